// File: doc/BRIEF.md
# Integer Divide and Remainder Unit

This block performs integer division for a 64-bit core. One request yields either the quotient or the remainder, signed or unsigned. A word-mode flag selects the 32-bit variants: the operands are extended from bit 31 before the divide, and the result is sign-extended from bit 31. The block never traps. A zero divisor and signed overflow each produce a fixed architectural value.

A request is a one-cycle `start` pulse with operands, `op_sel` and `word_mode` valid in that cycle. The normal path uses a restoring shift-subtract loop on operand magnitudes and produces one quotient bit per cycle. The signs of quotient and remainder are applied after the loop. Zero-divisor and overflow requests skip the loop and finish in one cycle.

The controller has four states:
- ST_IDLE waits for `start`.
- ST_RUN iterates the loop.
- ST_FIX applies signs and word extension.
- ST_DONE raises `done` for one cycle.

The transitions are:
- *launch* (ST_IDLE to ST_RUN, normal request).
- *shortcut* (ST_IDLE to ST_DONE, corner request).
- *last step* (ST_RUN to ST_FIX after XLEN steps).
- *settle* (ST_FIX to ST_DONE).
- *retire* (ST_DONE to ST_IDLE).

Top module: `div_unit`

## Requirements
- R1: With `op_sel`=2'b01 the result is the unsigned quotient rounded down; with 2'b11 it is the unsigned remainder (64-bit mode). Bit 0 of `op_sel` set means unsigned and bit 1 set means remainder.
- R2: With `op_sel`=2'b00 the signed quotient is truncated toward zero; with 2'b10 the signed remainder carries the sign of the dividend.
- R3: If the (extended) divisor is zero, both quotient operations (2'b00, 2'b01) return all ones.
- R4: If the (extended) divisor is zero, both remainder operations (2'b10, 2'b11) return the extended dividend, word-extended in word mode.
- R5: Signed overflow (dividend 0x8000_0000_0000_0000, divisor all ones) returns the dividend as the quotient and zero as the remainder. In word mode, dividend 0x8000_0000 with divisor 0xFFFF_FFFF returns 0xFFFF_FFFF_8000_0000 as the quotient and 0 as the remainder.
- R6: With `word_mode`=1 and a signed operation, both operands are sign-extended from bit 31, so bits 63:32 of the inputs have no effect.
- R7: With `word_mode`=1 and an unsigned operation, both operands are zero-extended from bit 31.
- R8: In word mode every result, unsigned ones included, is sign-extended from bit 31.
- R9: `done` rises 1 cycle after `start` for a zero divisor or a 64-bit signed overflow, and XLEN+2 cycles after `start` otherwise. `busy` is high from the cycle after `start` through the `done` cycle.
- R10: A `start` pulse while `busy` is high is ignored: the running request's result and latency are unchanged.
- R11: `done` is a one-cycle pulse, and `result` holds its value until a later request completes.
- R12: After reset, `busy`=0, `done`=0 and `result`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only when idle |
| op_sel | input | 2 | 00 signed quotient, 01 unsigned quotient, 10 signed remainder, 11 unsigned remainder |
| word_mode | input | 1 | Selects the 32-bit variants |
| opnd_a | input | XLEN | Dividend |
| opnd_b | input | XLEN | Divisor |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | XLEN | Quotient or remainder, held until the next completion |

## Verification
The embedded properties assume that `op_sel`, `word_mode` and both operands are stable in the cycle `start` is high. They also assume `rst_n` is released synchronously, away from a `start`. The bench drives every input on the falling clock edge and raises `start` for exactly one cycle. It changes operands only at that launch, except in the deliberate ignored-start scenario. That scenario pulses `start` mid-run with different operands so that R10 can be observed at the result.

// File: rtl/div_pkg.sv
package div_pkg;

    // Bit 0 of op_sel: unsigned; bit 1: remainder
    typedef enum logic [1:0] {
        OP_DIV  = 2'b00,
        OP_DIVU = 2'b01,
        OP_REM  = 2'b10,
        OP_REMU = 2'b11
    } div_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_FIX  = 2'b10,
        ST_DONE = 2'b11
    } div_state_e;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  logic [XLEN-1:0] a_in,
    input  logic [XLEN-1:0] b_in,
    input  logic [1:0]      op_sel,
    input  logic            word_mode,
    output logic [XLEN-1:0] a_ext,
    output logic [XLEN-1:0] a_mag,
    output logic [XLEN-1:0] b_mag,
    output logic            q_neg,
    output logic            r_neg,
    output logic            div_zero,
    output logic            sgn_ovf
);
    localparam int PAD = XLEN - WLEN;
    localparam logic [XLEN-1:0] MIN_VAL = {1'b1, {(XLEN-1){1'b0}}};

    logic            is_signed;
    logic [XLEN-1:0] b_ext;
    logic            a_neg;
    logic            b_neg;

    assign is_signed = ~op_sel[0];

    always_comb begin
        if (word_mode) begin
            if (is_signed) begin
                a_ext = {{PAD{a_in[WLEN-1]}}, a_in[WLEN-1:0]};
                b_ext = {{PAD{b_in[WLEN-1]}}, b_in[WLEN-1:0]};
            end else begin
                a_ext = {{PAD{1'b0}}, a_in[WLEN-1:0]};
                b_ext = {{PAD{1'b0}}, b_in[WLEN-1:0]};
            end
        end else begin
            a_ext = a_in;
            b_ext = b_in;
        end
    end

    assign a_neg    = is_signed & a_ext[XLEN-1];
    assign b_neg    = is_signed & b_ext[XLEN-1];
    assign a_mag    = a_neg ? (XLEN'(0) - a_ext) : a_ext;
    assign b_mag    = b_neg ? (XLEN'(0) - b_ext) : b_ext;
    assign q_neg    = a_neg ^ b_neg;
    assign r_neg    = a_neg;
    assign div_zero = (b_ext == '0);
    assign sgn_ovf  = is_signed & (a_ext == MIN_VAL) & (b_ext == '1);

endmodule

// File: rtl/div_iter_core.sv
module div_iter_core #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic [XLEN-1:0] dividend,
    input  logic [XLEN-1:0] divisor,
    output logic [XLEN-1:0] quo,
    output logic [XLEN-1:0] rem,
    output logic            last
);
    localparam int CW = $clog2(XLEN);

    logic [XLEN-1:0] quo_q;
    logic [XLEN-1:0] rem_q;
    logic [XLEN-1:0] dvs_q;
    logic [CW-1:0]   cnt_q;
    logic [XLEN:0]   shifted;
    logic [XLEN:0]   diff;
    logic            take;

    assign shifted = {rem_q, quo_q[XLEN-1]};
    assign diff    = shifted - {1'b0, dvs_q};
    assign take    = ~diff[XLEN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            quo_q <= dividend;
            rem_q <= '0;
            dvs_q <= divisor;
            cnt_q <= '0;
        end else if (step) begin
            rem_q <= take ? diff[XLEN-1:0] : shifted[XLEN-1:0];
            quo_q <= {quo_q[XLEN-2:0], take};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign quo  = quo_q;
    assign rem  = rem_q;
    assign last = (cnt_q == CW'(XLEN-1));

    // R1: partial remainder stays below the divisor after every step
    a_r1_partial_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (step && dvs_q != '0) |=> (rem_q < dvs_q));

endmodule

// File: rtl/div_result_fix.sv
module div_result_fix #(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  logic            use_raw,
    input  logic [XLEN-1:0] raw_val,
    input  logic [XLEN-1:0] quo_mag,
    input  logic [XLEN-1:0] rem_mag,
    input  logic            q_neg,
    input  logic            r_neg,
    input  logic            want_rem,
    input  logic            word_mode,
    output logic [XLEN-1:0] value
);
    localparam int PAD = XLEN - WLEN;

    logic [XLEN-1:0] quo_s;
    logic [XLEN-1:0] rem_s;
    logic [XLEN-1:0] pick;

    assign quo_s = q_neg ? (XLEN'(0) - quo_mag) : quo_mag;
    assign rem_s = r_neg ? (XLEN'(0) - rem_mag) : rem_mag;

    always_comb begin
        if (use_raw)       pick = raw_val;
        else if (want_rem) pick = rem_s;
        else               pick = quo_s;
    end

    assign value = word_mode ? {{PAD{pick[WLEN-1]}}, pick[WLEN-1:0]} : pick;

endmodule

// File: rtl/div_unit.sv
module div_unit
    import div_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      op_sel,
    input  logic            word_mode,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result
);
    div_state_e state_q, state_d;

    logic [XLEN-1:0] a_ext, a_mag, b_mag;
    logic            q_neg, r_neg, div_zero, sgn_ovf;
    logic            corner, accept, launch, shortcut, in_fix;
    logic            load, step, last;
    logic [XLEN-1:0] quo_mag, rem_mag, corner_val, fixed_val;
    logic            q_neg_q, r_neg_q, want_rem_q, word_q;
    logic [XLEN-1:0] result_q;

    div_operand_prep #(.XLEN(XLEN), .WLEN(WLEN)) u_prep (
        .a_in(opnd_a), .b_in(opnd_b), .op_sel(op_sel), .word_mode(word_mode),
        .a_ext(a_ext), .a_mag(a_mag), .b_mag(b_mag),
        .q_neg(q_neg), .r_neg(r_neg), .div_zero(div_zero), .sgn_ovf(sgn_ovf)
    );

    assign corner   = div_zero | sgn_ovf;
    assign accept   = (state_q == ST_IDLE) && start;
    assign launch   = accept && !corner;
    assign shortcut = accept && corner;

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (shortcut)    state_d = ST_DONE;
                else if (launch) state_d = ST_RUN;
            end
            ST_RUN:  if (last) state_d = ST_FIX;
            ST_FIX:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output and control decode
    always_comb begin
        busy   = 1'b0;
        done   = 1'b0;
        step   = 1'b0;
        in_fix = 1'b0;
        load   = launch;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  begin busy = 1'b1; step = 1'b1; end
            ST_FIX:  begin busy = 1'b1; in_fix = 1'b1; end
            ST_DONE: begin busy = 1'b1; done = 1'b1; end
        endcase
    end

    div_iter_core #(.XLEN(XLEN)) u_core (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .dividend(a_mag), .divisor(b_mag),
        .quo(quo_mag), .rem(rem_mag), .last(last)
    );

    // Request context captured at launch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_neg_q    <= 1'b0;
            r_neg_q    <= 1'b0;
            want_rem_q <= 1'b0;
            word_q     <= 1'b0;
        end else if (launch) begin
            q_neg_q    <= q_neg;
            r_neg_q    <= r_neg;
            want_rem_q <= op_sel[1];
            word_q     <= word_mode;
        end
    end

    always_comb begin
        if (div_zero) corner_val = op_sel[1] ? a_ext : '1;
        else          corner_val = op_sel[1] ? '0 : a_ext;
    end

    div_result_fix #(.XLEN(XLEN), .WLEN(WLEN)) u_fix (
        .use_raw(!in_fix), .raw_val(corner_val),
        .quo_mag(quo_mag), .rem_mag(rem_mag),
        .q_neg(q_neg_q), .r_neg(r_neg_q),
        .want_rem(in_fix ? want_rem_q : op_sel[1]),
        .word_mode(in_fix ? word_q : word_mode),
        .value(fixed_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                result_q <= '0;
        else if (shortcut || in_fix) result_q <= fixed_val;
    end

    assign result = result_q;

    // R11: done lasts one cycle
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: busy drops right after done
    a_r9_done_releases_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R9: corner requests finish in one cycle
    a_r9_shortcut_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && (div_zero || sgn_ovf)) |=> done);
    // R9: normal requests go busy without done
    a_r9_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && !div_zero && !sgn_ovf) |=> (busy && !done));
    // R10: start in a busy state leaves the state path alone
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !last) |=> (state_q == ST_RUN));
    // R3: zero divisor quotient is all ones
    a_r3_div_zero_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && div_zero && !op_sel[1]) |=> (result == '1));
    // R4: zero divisor remainder returns dividend
    a_r4_rem_zero_dividend: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && div_zero && op_sel[1] && !word_mode)
        |=> (result == $past(opnd_a)));
    // R5: overflow remainder is zero
    a_r5_overflow_rem: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && sgn_ovf && op_sel[1]) |=> (result == '0));
    // R11: result holds outside completion updates
    a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_FIX && !(state_q == ST_IDLE && start)) |=> $stable(result));

endmodule

// File: tb/div_unit_tb.sv
`timescale 1ns/1ps
module div_unit_tb;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [1:0]      op_sel = 2'b00;
    logic            word_mode = 1'b0;
    logic [XLEN-1:0] opnd_a = '0;
    logic [XLEN-1:0] opnd_b = '0;
    logic            busy, done;
    logic [XLEN-1:0] result;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    div_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .word_mode(word_mode), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .busy(busy), .done(done), .result(result)
    );

    localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;

    function automatic logic [63:0] extend(input logic [63:0] v, input logic sgn, input logic w);
        if (!w)  return v;
        if (sgn) return {{32{v[31]}}, v[31:0]};
        return {32'b0, v[31:0]};
    endfunction

    function automatic logic is_corner(input logic [63:0] a, input logic [63:0] b,
                                       input logic [1:0] op, input logic w);
        logic sgn;
        logic [63:0] ae, be;
        sgn = ~op[0];
        ae = extend(a, sgn, w);
        be = extend(b, sgn, w);
        return (be == 0) || (sgn && ae == MINV && be == '1);
    endfunction

    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input logic [1:0] op, input logic w);
        logic sgn;
        logic [63:0] ae, be, r;
        logic signed [63:0] sa, sb;
        sgn = ~op[0];
        ae = extend(a, sgn, w);
        be = extend(b, sgn, w);
        if (be == 0)                             r = op[1] ? ae : '1;
        else if (sgn && ae == MINV && be == '1)  r = op[1] ? 64'd0 : ae;
        else if (sgn) begin
            sa = ae; sb = be;
            r = op[1] ? 64'(sa % sb) : 64'(sa / sb);
        end else
            r = op[1] ? ae % be : ae / be;
        if (w) r = {{32{r[31]}}, r[31:0]};
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Launch one request, wait for done, check value, latency and busy
    task automatic run_op(input string req, input logic [63:0] a, input logic [63:0] b,
                          input logic [1:0] op, input logic w);
        int lat;
        int exp_lat;
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_sel = op; word_mode = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({req, " R9 busy"}, 64'(busy), 64'd1);
        lat = 1;
        while (!done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        exp_lat = is_corner(a, b, op, w) ? 1 : XLEN + 2;
        chk({req, " R9 latency"}, 64'(lat), 64'(exp_lat));
        chk(req, result, model(a, b, op, w));
        @(negedge clk);
        chk({req, " R11 done pulse"}, 64'(done), 64'd0);
    endtask

    task automatic t_reset();
        chk("R12 busy", 64'(busy), 64'd0);
        chk("R12 done", 64'(done), 64'd0);
        chk("R12 result", result, 64'd0);
    endtask

    task automatic t_unsigned();
        run_op("R1 divu", 64'd1000, 64'd7, 2'b01, 1'b0);
        run_op("R1 remu", 64'd1000, 64'd7, 2'b11, 1'b0);
        run_op("R1 divu big", 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 2'b01, 1'b0);
        run_op("R1 remu big", 64'hF123_4567_89AB_CDEF, 64'h0000_0001_0000_0003, 2'b11, 1'b0);
        run_op("R1 divu small by big", 64'd5, 64'hFFFF_0000_0000_0000, 2'b01, 1'b0);
    endtask

    task automatic t_signed();
        run_op("R2 div neg/pos", -64'sd100, 64'd7, 2'b00, 1'b0);
        run_op("R2 div pos/neg", 64'd100, -64'sd7, 2'b00, 1'b0);
        run_op("R2 div neg/neg", -64'sd100, -64'sd7, 2'b00, 1'b0);
        run_op("R2 rem neg/pos", -64'sd100, 64'd7, 2'b10, 1'b0);
        run_op("R2 rem pos/neg", 64'd100, -64'sd7, 2'b10, 1'b0);
        run_op("R2 div min by 2", MINV, 64'd2, 2'b00, 1'b0);
    endtask

    task automatic t_zero();
        run_op("R3 div by zero", 64'd1234, 64'd0, 2'b00, 1'b0);
        run_op("R3 divu by zero", 64'hDEAD_BEEF, 64'd0, 2'b01, 1'b0);
        run_op("R4 rem by zero", -64'sd55, 64'd0, 2'b10, 1'b0);
        run_op("R4 remu by zero", 64'hCAFE_0000_1111_2222, 64'd0, 2'b11, 1'b0);
        run_op("R4 remu word by zero", 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_0000_0000, 2'b11, 1'b1);
        run_op("R3 div word by zero", 64'd9, 64'h0000_0001_0000_0000, 2'b00, 1'b1);
    endtask

    task automatic t_overflow();
        run_op("R5 div overflow", MINV, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 1'b0);
        run_op("R5 rem overflow", MINV, 64'hFFFF_FFFF_FFFF_FFFF, 2'b10, 1'b0);
        run_op("R5 div word overflow", 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 2'b00, 1'b1);
        run_op("R5 rem word overflow", 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 2'b10, 1'b1);
    endtask

    task automatic t_word_signed();
        run_op("R6 divw upper ignored", 64'hABCD_0000_FFFF_FF9C, 64'h1234_5678_0000_0007, 2'b00, 1'b1);
        run_op("R6 remw upper ignored", 64'h5555_5555_FFFF_FF9C, 64'h0F0F_0F0F_0000_0007, 2'b10, 1'b1);
    endtask

    task automatic t_word_unsigned();
        run_op("R7 divuw", 64'hFFFF_FFFF_FFFF_FFFE, 64'h8000_0000_0000_0002, 2'b01, 1'b1);
        run_op("R8 divuw sext", 64'h0000_0000_FFFF_FFFF, 64'd1, 2'b01, 1'b1);
        run_op("R8 remuw sext", 64'h0000_0000_F000_0005, 64'hFFFF_FFFF_F000_0006, 2'b11, 1'b1);
    endtask

    task automatic t_ignore_start();
        int lat;
        @(negedge clk);
        opnd_a = 64'd999; opnd_b = 64'd10; op_sel = 2'b01; word_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        repeat (5) begin @(negedge clk); lat++; end
        opnd_a = 64'd7; opnd_b = 64'd0; op_sel = 2'b10; start = 1'b1;
        @(negedge clk);
        lat++;
        start = 1'b0;
        while (!done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        chk("R10 latency unchanged", 64'(lat), 64'(XLEN + 2));
        chk("R10 result of first request", result, 64'd99);
        @(negedge clk);
    endtask

    task automatic t_hold();
        logic [63:0] held;
        run_op("R11 setup", 64'd77, 64'd5, 2'b11, 1'b0);
        held = result;
        opnd_a = 64'd1; opnd_b = 64'd0; op_sel = 2'b00;
        repeat (4) @(negedge clk);
        chk("R11 result held", result, held);
        chk("R11 idle", 64'(busy), 64'd0);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_unsigned();
        t_signed();
        t_zero();
        t_overflow();
        t_word_signed();
        t_word_unsigned();
        t_ignore_start();
        t_hold();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule